// File: doc/BRIEF.md
# Windowed Burst Write Master

This block turns write requests from user logic into AXI4 incrementing write bursts aimed at an external memory. Each request gives a byte offset and a beat count. The data words arrive through a separate valid/ready port. The block adds a runtime base address to the offset to form the bus address. Together with a runtime byte size, that base also bounds a partition window, and no request may write outside it.

The block checks each request at the moment it is accepted. If the request is misaligned or would run past the end of the window, it is refused: no address or data leaves the block, and the requester gets an error completion on the next cycle. A request that passes the check gets one address handshake and the requested number of data beats, and then the block waits for the write response. Only one burst is in flight at a time. Each request ends with a single-cycle completion pulse that carries a range-error flag, a bus-error flag and the raw response code.

Top module: `win_burst_writer`

## Requirements
- R1: While reset is held, and until a request arrives after it, awvalid, wvalid, bready and doneValid are low and reqReady is high.
- R2: An accepted request issues exactly one address handshake. Its fields are: awaddr equal to winBase plus reqOffset (modulo 2^32), awlen equal to reqBeatsM1, awsize equal to log2 of the bytes per data word, awburst equal to 01 (incrementing) and awlock equal to 0. Cache and protection take the values of the CACHE_ATTR and PROT_ATTR parameters.
- R3: A request is refused in two cases: its offset is not a multiple of the bytes per data word, or offset + (reqBeatsM1+1) × bytes per word, computed without overflow, exceeds winSize. A refused request causes no awvalid and no wvalid, and completes in the cycle right after acceptance with doneRangeErr=1, doneBusErr=0 and doneResp=00. A request that ends exactly at winSize is accepted.
- R4: An accepted request sends exactly reqBeatsM1+1 data beats. Each beat carries the user word and strobe, passed through in order. wlast is high on the final beat only, and no wvalid follows it.
- R5: While awvalid is high and awready is low, awvalid stays high and awaddr stays unchanged.
- R6: reqReady is low from the acceptance of a request until its completion pulse, so at most one burst is outstanding.
- R7: bready is raised only after the address handshake and all data beats are complete. The completion reports doneResp equal to bresp, and doneBusErr=1 for any code other than 00 (01, 10 and 11 are all errors).
- R8: doneValid is a one-cycle pulse in the cycle after the response handshake. reqReady is high again in the cycle after the pulse.
- R9: awqos is the QOS_LEVEL parameter clamped to at most 7, so a setting of 12 drives 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| winBase | input | 32 | Window base byte address |
| winSize | input | 32 | Window size in bytes |
| reqValid | input | 1 | Request offered |
| reqReady | output | 1 | Request accepted when both high |
| reqOffset | input | 32 | Byte offset into the window |
| reqBeatsM1 | input | 8 | Beat count minus one |
| dataValid | input | 1 | User data word offered |
| dataReady | output | 1 | User data word taken |
| dataWord | input | DATA_W | User data word |
| dataStrb | input | DATA_W/8 | User byte enables |
| doneValid | output | 1 | Completion pulse |
| doneRangeErr | output | 1 | Request refused by window check |
| doneBusErr | output | 1 | Response was not OKAY |
| doneResp | output | 2 | Raw response code |
| awaddr | output | 32 | Write address |
| awlen | output | 8 | Burst length minus one |
| awsize | output | 3 | log2 bytes per beat |
| awburst | output | 2 | Burst type (01) |
| awlock | output | 1 | Lock (0) |
| awcache | output | 4 | Cache attributes |
| awprot | output | 3 | Protection attributes |
| awqos | output | 4 | Quality of service |
| awvalid | output | 1 | Address valid |
| awready | input | 1 | Address ready |
| wdata | output | DATA_W | Write data |
| wstrb | output | DATA_W/8 | Write strobes |
| wlast | output | 1 | Final beat |
| wvalid | output | 1 | Data valid |
| wready | input | 1 | Data ready |
| bresp | input | 2 | Write response code |
| bvalid | input | 1 | Response valid |
| bready | output | 1 | Response ready |

## Verification
Requests are swept over every aligned offset across a 64-byte window and a little past it, with beat counts that fit exactly, fall short, or overrun the window by one word. This separates an off-by-one in the end comparison from a correct check. Misaligned offsets, a 256-beat burst, and an offset near 2^32 whose end would wrap test the alignment rule and the overflow-free sum. Each sweep runs three ways: with both slave readies always high, with address and data readies throttled on different periods, and with gaps in the user data. Together these separate errors in beat counting, in wlast placement and in holding the address stable under back-pressure. The response code cycles through all four values, which shows that only 00 counts as success.

// File: rtl/wbw_pkg.sv
package wbw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SEND  = 2'd1,
    ST_WAITB = 2'd2,
    ST_DONE  = 2'd3
  } wbwState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic reject;
    logic awFire;
    logic wFire;
    logic bFire;
  } wbwCtl_t;

  function automatic logic [3:0] clampQos(input int level);
    return (level > 7) ? 4'd7 : 4'(level);
  endfunction

endpackage

// File: rtl/wbw_datapath.sv
module wbw_datapath
  import wbw_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [31:0] winBase,
  input  logic [31:0] winSize,
  input  logic [31:0] reqOffset,
  input  logic [7:0]  reqBeatsM1,
  input  logic [1:0]  bresp,
  input  wbwCtl_t     ctl,
  output logic [31:0] awAddr,
  output logic [7:0]  awLen,
  output logic        inWindow,
  output logic        awSent,
  output logic        allSent,
  output logic        lastBeat,
  output logic        doneRangeErr,
  output logic        doneBusErr,
  output logic [1:0]  doneResp
);

  localparam int BPB      = DATA_W / 8;
  localparam int SIZE_LOG = $clog2(BPB);

  logic [8:0]  reqBeats;
  logic [33:0] reqBytes;
  logic [33:0] reqEnd;
  logic        reqAligned;
  logic [7:0]  beatCnt;

  assign reqBeats   = {1'b0, reqBeatsM1} + 9'd1;
  assign reqBytes   = {25'd0, reqBeats} << SIZE_LOG;
  assign reqEnd     = {2'b00, reqOffset} + reqBytes;
  assign reqAligned = (reqOffset & 32'(BPB - 1)) == 32'd0;
  assign inWindow   = reqAligned && (reqEnd <= {2'b00, winSize});
  assign lastBeat   = (beatCnt == awLen);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      awAddr  <= '0;
      awLen   <= '0;
      beatCnt <= '0;
      awSent  <= 1'b0;
      allSent <= 1'b0;
    end else if (ctl.loadReq) begin
      awAddr  <= winBase + reqOffset;
      awLen   <= reqBeatsM1;
      beatCnt <= '0;
      awSent  <= 1'b0;
      allSent <= 1'b0;
    end else begin
      if (ctl.awFire) awSent <= 1'b1;
      if (ctl.wFire) begin
        beatCnt <= beatCnt + 8'd1;
        if (lastBeat) allSent <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneRangeErr <= 1'b0;
      doneBusErr   <= 1'b0;
      doneResp     <= 2'b00;
    end else if (ctl.reject) begin
      doneRangeErr <= 1'b1;
      doneBusErr   <= 1'b0;
      doneResp     <= 2'b00;
    end else if (ctl.loadReq) begin
      doneRangeErr <= 1'b0;
      doneBusErr   <= 1'b0;
      doneResp     <= 2'b00;
    end else if (ctl.bFire) begin
      doneBusErr <= (bresp != 2'b00);
      doneResp   <= bresp;
    end
  end

  // R4
  beat_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctl.wFire && allSent |-> 1'b0);

endmodule

// File: rtl/wbw_control.sv
module wbw_control
  import wbw_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    inWindow,
  input  logic    awSent,
  input  logic    allSent,
  input  logic    lastBeat,
  input  logic    awReady,
  input  logic    dataValid,
  input  logic    wReady,
  input  logic    bValid,
  output logic    reqReady,
  output logic    awValid,
  output logic    wValid,
  output logic    dataReady,
  output logic    wLast,
  output logic    bReady,
  output logic    doneValid,
  output wbwCtl_t ctl
);

  wbwState_t state, stateNext;
  logic      wActive;
  logic      addrDone;
  logic      dataDone;

  assign reqReady  = (state == ST_IDLE);
  assign awValid   = (state == ST_SEND) && !awSent;
  assign wActive   = (state == ST_SEND) && !allSent;
  assign wValid    = dataValid && wActive;
  assign dataReady = wReady && wActive;
  assign wLast     = wActive && lastBeat;
  assign bReady    = (state == ST_WAITB);
  assign doneValid = (state == ST_DONE);

  always_comb begin
    ctl         = '0;
    ctl.loadReq = reqReady && reqValid && inWindow;
    ctl.reject  = reqReady && reqValid && !inWindow;
    ctl.awFire  = awValid && awReady;
    ctl.wFire   = wValid && wReady;
    ctl.bFire   = bReady && bValid;
  end

  assign addrDone = awSent || ctl.awFire;
  assign dataDone = allSent || (ctl.wFire && lastBeat);

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (ctl.loadReq)     stateNext = ST_SEND;
        else if (ctl.reject) stateNext = ST_DONE;
      end
      ST_SEND:  if (addrDone && dataDone) stateNext = ST_WAITB;
      ST_WAITB: if (ctl.bFire) stateNext = ST_DONE;
      ST_DONE:  stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid && reqReady);

  // R4
  last_beat_chk: assert property (@(posedge clk) disable iff (!rstN)
    wValid && wReady && wLast |=> !wValid);

  // R7
  resp_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    bReady |-> !awValid && !wValid);

endmodule

// File: rtl/win_burst_writer.sv
module win_burst_writer
  import wbw_pkg::*;
#(
  parameter int         DATA_W     = 32,
  parameter logic [3:0] CACHE_ATTR = 4'b0011,
  parameter logic [2:0] PROT_ATTR  = 3'b000,
  parameter int         QOS_LEVEL  = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [31:0]         winBase,
  input  logic [31:0]         winSize,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic [31:0]         reqOffset,
  input  logic [7:0]          reqBeatsM1,
  input  logic                dataValid,
  output logic                dataReady,
  input  logic [DATA_W-1:0]   dataWord,
  input  logic [DATA_W/8-1:0] dataStrb,
  output logic                doneValid,
  output logic                doneRangeErr,
  output logic                doneBusErr,
  output logic [1:0]          doneResp,
  output logic [31:0]         awaddr,
  output logic [7:0]          awlen,
  output logic [2:0]          awsize,
  output logic [1:0]          awburst,
  output logic                awlock,
  output logic [3:0]          awcache,
  output logic [2:0]          awprot,
  output logic [3:0]          awqos,
  output logic                awvalid,
  input  logic                awready,
  output logic [DATA_W-1:0]   wdata,
  output logic [DATA_W/8-1:0] wstrb,
  output logic                wlast,
  output logic                wvalid,
  input  logic                wready,
  input  logic [1:0]          bresp,
  input  logic                bvalid,
  output logic                bready
);

  localparam int         BPB      = DATA_W / 8;
  localparam int         SIZE_LOG = $clog2(BPB);
  localparam logic [3:0] QOS_USE  = clampQos(QOS_LEVEL);

  wbwCtl_t ctl;
  logic    inWindow;
  logic    awSent;
  logic    allSent;
  logic    lastBeat;

  wbw_datapath #(.DATA_W(DATA_W)) uDatapath (
    .clk          (clk),
    .rstN         (rstN),
    .winBase      (winBase),
    .winSize      (winSize),
    .reqOffset    (reqOffset),
    .reqBeatsM1   (reqBeatsM1),
    .bresp        (bresp),
    .ctl          (ctl),
    .awAddr       (awaddr),
    .awLen        (awlen),
    .inWindow     (inWindow),
    .awSent       (awSent),
    .allSent      (allSent),
    .lastBeat     (lastBeat),
    .doneRangeErr (doneRangeErr),
    .doneBusErr   (doneBusErr),
    .doneResp     (doneResp)
  );

  wbw_control uControl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .inWindow  (inWindow),
    .awSent    (awSent),
    .allSent   (allSent),
    .lastBeat  (lastBeat),
    .awReady   (awready),
    .dataValid (dataValid),
    .wReady    (wready),
    .bValid    (bvalid),
    .reqReady  (reqReady),
    .awValid   (awvalid),
    .wValid    (wvalid),
    .dataReady (dataReady),
    .wLast     (wlast),
    .bReady    (bready),
    .doneValid (doneValid),
    .ctl       (ctl)
  );

  assign awsize  = 3'(SIZE_LOG);
  assign awburst = 2'b01;
  assign awlock  = 1'b0;
  assign awcache = CACHE_ATTR;
  assign awprot  = PROT_ATTR;
  assign awqos   = QOS_USE;
  assign wdata   = dataWord;
  assign wstrb   = dataStrb;

  logic [33:0] burstEnd;
  assign burstEnd = {2'b00, awaddr - winBase}
                  + ({25'd0, {1'b0, awlen} + 9'd1} << SIZE_LOG);

  // R3
  in_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    awvalid |-> burstEnd <= {2'b00, winSize});

  // R5
  aw_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    awvalid && !awready |=> awvalid && $stable(awaddr));

  // R3
  reject_fast_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid && doneRangeErr |-> $past(reqReady));

endmodule

// File: tb/test_win_burst_writer.sv
module test_win_burst_writer;

  localparam int DW = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] winBase = '0, winSize = '0, reqOffset = '0;
  logic        reqValid = 1'b0;
  logic [7:0]  reqBeatsM1 = '0;
  logic        dataValid = 1'b0;
  logic [DW-1:0]   dataWord = '0;
  logic [DW/8-1:0] dataStrb = '0;
  logic        awready = 1'b0, wready = 1'b0, bvalid = 1'b0;
  logic [1:0]  bresp = 2'b00;

  logic        reqReady, dataReady, doneValid, doneRangeErr, doneBusErr;
  logic [1:0]  doneResp;
  logic [31:0] awaddr;
  logic [7:0]  awlen;
  logic [2:0]  awsize, awprot;
  logic [1:0]  awburst;
  logic        awlock, awvalid, wlast, wvalid, bready;
  logic [3:0]  awcache, awqos;
  logic [DW-1:0]   wdata;
  logic [DW/8-1:0] wstrb;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  win_burst_writer #(
    .DATA_W(DW), .CACHE_ATTR(4'b0011), .PROT_ATTR(3'b010), .QOS_LEVEL(12)
  ) i_win_burst_writer (
    .clk(clk), .rstN(rstN), .winBase(winBase), .winSize(winSize),
    .reqValid(reqValid), .reqReady(reqReady), .reqOffset(reqOffset),
    .reqBeatsM1(reqBeatsM1), .dataValid(dataValid), .dataReady(dataReady),
    .dataWord(dataWord), .dataStrb(dataStrb), .doneValid(doneValid),
    .doneRangeErr(doneRangeErr), .doneBusErr(doneBusErr), .doneResp(doneResp),
    .awaddr(awaddr), .awlen(awlen), .awsize(awsize), .awburst(awburst),
    .awlock(awlock), .awcache(awcache), .awprot(awprot), .awqos(awqos),
    .awvalid(awvalid), .awready(awready), .wdata(wdata), .wstrb(wstrb),
    .wlast(wlast), .wvalid(wvalid), .wready(wready), .bresp(bresp),
    .bvalid(bvalid), .bready(bready)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input logic [31:0] off, input int idx);
    return 32'hA500_0000 ^ (off << 8) ^ 32'(idx);
  endfunction

  task automatic doReq(input logic [31:0] base, input logic [31:0] size,
                       input logic [31:0] off, input int n, input int mode,
                       input logic [1:0] resp);
    bit expRej;
    bit awSeen = 0;
    bit bDone = 0;
    bit prevAwWait = 0;
    logic [31:0] prevAddr = '0;
    int wIdx = 0;
    int bCycle = -10;
    int c;
    longint endB;
    endB = longint'(off) + longint'(n) * 4;
    expRej = (off[1:0] != 2'b00) || (endB > longint'(size));
    @(negedge clk);
    winBase = base; winSize = size; reqOffset = off;
    reqBeatsM1 = 8'(n - 1); reqValid = 1'b1;
    #2;
    check(reqReady === 1'b1, "R6 ready before request", longint'(reqReady), 1);
    for (c = 0; c < 3000; c++) begin
      @(negedge clk);
      reqValid  = 1'b0;
      awready   = (mode == 1) ? (c % 3 == 2) : 1'b1;
      wready    = (mode == 1) ? (c % 2 == 1) : 1'b1;
      dataValid = (wIdx < n) && ((mode == 2) ? (c % 4 != 1) : 1'b1);
      dataWord  = pattern(off, wIdx);
      dataStrb  = 4'(wIdx * 5 + 1);
      bvalid    = !bDone && awSeen && (wIdx == n);
      bresp     = resp;
      #2;
      if (doneValid) break;
      check(reqReady === 1'b0, "R6 busy", longint'(reqReady), 0);
      if (expRej)
        check(!awvalid && !wvalid, "R3 no traffic", longint'({awvalid, wvalid}), 0);
      if (prevAwWait)
        check(awvalid && awaddr == prevAddr, "R5 hold", longint'(awaddr), longint'(prevAddr));
      if (bready)
        check(awSeen && wIdx == n, "R7 bready order", longint'(wIdx), longint'(n));
      if (awvalid && awready) begin
        check(!awSeen, "R2 single address", 1, 0);
        check(awaddr == base + off, "R2 awaddr", longint'(awaddr), longint'(base + off));
        check(awlen == 8'(n - 1), "R2 awlen", longint'(awlen), longint'(n - 1));
        check(awsize == 3'd2 && awburst == 2'b01 && !awlock, "R2 size/burst/lock",
              longint'({awsize, awburst, awlock}), longint'({3'd2, 2'b01, 1'b0}));
        check(awcache == 4'b0011 && awprot == 3'b010, "R2 cache/prot",
              longint'({awcache, awprot}), longint'({4'b0011, 3'b010}));
        check(awqos == 4'd7, "R9 qos clamp", longint'(awqos), 7);
        awSeen = 1;
      end
      prevAwWait = awvalid && !awready;
      prevAddr   = awaddr;
      if (wvalid && wready) begin
        check(wIdx < n, "R4 extra beat", longint'(wIdx), longint'(n));
        check(wdata == pattern(off, wIdx) && wstrb == 4'(wIdx * 5 + 1), "R4 data",
              longint'(wdata), longint'(pattern(off, wIdx)));
        check(wlast == (wIdx == n - 1), "R4 wlast", longint'(wlast), longint'(wIdx == n - 1));
        wIdx++;
      end
      if (bready && bvalid) begin
        bDone = 1;
        bCycle = c;
      end
    end
    bvalid = 1'b0;
    if (c == 3000) check(1'b0, "R8 completion timeout", 0, 1);
    else if (expRej) begin
      check(c == 0, "R3 reject latency", longint'(c), 0);
      check(doneRangeErr && !doneBusErr && doneResp == 2'b00, "R3 reject flags",
            longint'({doneRangeErr, doneBusErr, doneResp}), longint'(4'b1000));
    end else begin
      check(c == bCycle + 1, "R8 done timing", longint'(c), longint'(bCycle + 1));
      check(wIdx == n, "R4 beat count", longint'(wIdx), longint'(n));
      check(!doneRangeErr && doneBusErr == (resp != 2'b00) && doneResp == resp,
            "R7 response", longint'({doneRangeErr, doneBusErr, doneResp}),
            longint'({1'b0, resp != 2'b00, resp}));
    end
    @(negedge clk);
    #2;
    check(!doneValid && reqReady, "R8 pulse end", longint'({doneValid, reqReady}), 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int nList[7] = '{1, 2, 3, 8, 15, 16, 17};
    int k = 0;
    repeat (3) @(negedge clk);
    #2;
    check(!awvalid && !wvalid && !bready && !doneValid && reqReady, "R1 reset",
          longint'({awvalid, wvalid, bready, doneValid, reqReady}), 1);
    @(negedge clk);
    rstN = 1'b1;
    #2;
    check(!awvalid && !wvalid && !bready && !doneValid && reqReady, "R1 after reset",
          longint'({awvalid, wvalid, bready, doneValid, reqReady}), 1);
    for (int mode = 0; mode < 3; mode++)
      for (int off = 0; off <= 68; off += 4)
        for (int j = 0; j < 7; j++) begin
          doReq(32'h1000_0000, 32'd64, 32'(off), nList[j], mode, 2'(k));
          k++;
        end
    for (int r = 0; r < 4; r++) doReq(32'h2000_0000, 32'd64, 32'd8, 2, 1, 2'(r));
    doReq(32'h1000_0000, 32'd64, 32'd1, 1, 0, 2'b00);
    doReq(32'h1000_0000, 32'd64, 32'd6, 1, 0, 2'b00);
    doReq(32'h0, 32'd1024, 32'd0, 256, 0, 2'b00);
    doReq(32'h0, 32'd1024, 32'd4, 256, 1, 2'b00);
    doReq(32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFC, 2, 0, 2'b00);
    doReq(32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFF8, 1, 0, 2'b00);
    doReq(32'h8000_0000, 32'd16, 32'd12, 1, 2, 2'b11);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule